// File: doc/BRIEF.md
# Programmable Multi-Output Symmetric Function Array

This block evaluates several Boolean functions of `NVAR` input variables. Each output is built as a logical OR of symmetric functions. A symmetric function's value depends only on how many of its inputs are one. The array has two evaluation stages. Each stage first passes the inputs through its own polarity vector, which can complement any variable. A lattice of 2:1 multiplexer cells then turns the polarised inputs into the full set of weight indicators S0..Sn. Indicator Sk is high exactly when k of the polarised inputs are one.

The lattice has one level per variable. Each cell passes on one of two neighbouring nodes from the level above, and the variable of that level controls the choice. No variable controls more than one level, so a single shared lattice exposes every weight of a stage at once.

A programmable OR plane combines the 2·(n+1) indicators of both stages into `NOUT` outputs. The configuration is two polarity vectors and one OR mask per output. It is loaded through a synchronous register-write port. The function outputs are purely combinational from the input variables and the stored configuration.

Top module: `symarr_top`

## Requirements
- R1: After an active-low reset every polarity bit and every mask bit is zero, so every output reads 0 for every input value.
- R2: In stage s, indicator Sk is high exactly when the number of ones in (vars_in XOR polarity_s) equals k. A polarity bit of 1 complements that variable.
- R3: For any input, exactly one indicator of each stage is high.
- R4: Output j is the OR of the indicators selected by mask j. Mask bit k (0 ≤ k ≤ NVAR) selects stage-0 Sk. Mask bit NVAR+1+k selects stage-1 Sk.
- R5: A write with cfg_we high is stored on the rising clock edge. Address 0 loads polarity 0 from cfg_wdata[NVAR-1:0]. Address 1 loads polarity 1 from the same bits. Address 2+j loads mask j from all of cfg_wdata.
- R6: A write to an address at or above 2+NOUT changes no configuration and no output.
- R7: An output whose mask is all zeros is 0 for every input.
- R8: An output whose mask selects every indicator of one stage is 1 for every input.
- R9: The outputs follow vars_in combinationally, with no clock edge in between.
- R10: While cfg_we is low the configuration holds, whatever cfg_addr and cfg_wdata carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | $clog2(NOUT+2) | Configuration register address |
| cfg_wdata | input | 2*(NVAR+1) | Configuration write data |
| vars_in | input | NVAR | Input variables |
| func_out | output | NOUT | Function outputs |

## Verification
The assertions assume the following about the inputs:
- Inputs carry known values at every rising edge after reset.
- The configuration port is steady around that edge.
- vars_in has settled by the edge, so the sampled indicators match the sampled inputs.

The stimulus stays within these limits:
- It changes every input only on the falling edge.
- It starts with reset asserted.
- The only out-of-map traffic is writes to the unused addresses above the mask registers. This is exactly the case R6 covers.

// File: rtl/symarr_pkg.sv
package symarr_pkg;

    typedef enum logic [1:0] {
        KIND_POL0,
        KIND_POL1,
        KIND_MASK,
        KIND_NONE
    } reg_kind_e;

    function automatic reg_kind_e addr_kind(input int unsigned a, input int unsigned nout);
        if (a == 0)
            return KIND_POL0;
        if (a == 1)
            return KIND_POL1;
        if (a < nout + 2)
            return KIND_MASK;
        return KIND_NONE;
    endfunction

endpackage

// File: rtl/symarr_cfg.sv
module symarr_cfg
    import symarr_pkg::*;
#(
    parameter int NVAR = 4,
    parameter int NOUT = 4,
    parameter int MW   = 2 * (NVAR + 1),
    parameter int AW   = $clog2(NOUT + 2)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [AW-1:0]             wr_addr,
    input  logic [MW-1:0]             wr_data,
    output logic [NVAR-1:0]           pol0_q,
    output logic [NVAR-1:0]           pol1_q,
    output logic [NOUT-1:0][MW-1:0]   mask_q
);

    reg_kind_e kind;

    always_comb begin
        kind = addr_kind(int'(wr_addr), NOUT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pol0_q <= '0;
            pol1_q <= '0;
        end else if (wr_en) begin
            unique case (kind)
                KIND_POL0: pol0_q <= wr_data[NVAR-1:0];
                KIND_POL1: pol1_q <= wr_data[NVAR-1:0];
                default:   ;
            endcase
        end
    end

    for (genvar j = 0; j < NOUT; j++) begin : g_mask
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mask_q[j] <= '0;
            else if (wr_en && kind == KIND_MASK && wr_addr == AW'(j + 2))
                mask_q[j] <= wr_data;
        end
    end

endmodule

// File: rtl/symarr_lattice.sv
module symarr_lattice #(
    parameter int NVAR = 4,
    parameter int W    = NVAR + 1
) (
    input  logic [NVAR-1:0] vars,
    input  logic [NVAR-1:0] pol,
    output logic [W-1:0]    weight
);

    logic [NVAR-1:0] pv;
    assign pv = vars ^ pol;

    for (genvar i = 0; i < NVAR; i++) begin : g_lvl
        logic [W-1:0] prev;
        logic [W-1:0] node;
        if (i == 0) begin : g_first
            assign prev = W'(1);
        end else begin : g_rest
            assign prev = g_lvl[i-1].node;
        end
        for (genvar k = 0; k < W; k++) begin : g_cell
            if (k == 0) begin : g_edge
                assign node[k] = pv[i] ? 1'b0 : prev[k];
            end else begin : g_mux
                assign node[k] = pv[i] ? prev[k-1] : prev[k];
            end
        end
    end

    assign weight = g_lvl[NVAR-1].node;

endmodule

// File: rtl/symarr_orplane.sv
module symarr_orplane #(
    parameter int NVAR = 4,
    parameter int NOUT = 4,
    parameter int W    = NVAR + 1,
    parameter int MW   = 2 * W
) (
    input  logic [NOUT-1:0][MW-1:0] mask,
    input  logic [W-1:0]            w0,
    input  logic [W-1:0]            w1,
    output logic [NOUT-1:0]         y
);

    logic [MW-1:0] ind;
    assign ind = {w1, w0};

    for (genvar j = 0; j < NOUT; j++) begin : g_out
        assign y[j] = |(mask[j] & ind);
    end

endmodule

// File: rtl/symarr_top.sv
module symarr_top #(
    parameter  int NVAR = 4,
    parameter  int NOUT = 4,
    localparam int W    = NVAR + 1,
    localparam int MW   = 2 * W,
    localparam int AW   = $clog2(NOUT + 2)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [AW-1:0]   cfg_addr,
    input  logic [MW-1:0]   cfg_wdata,
    input  logic [NVAR-1:0] vars_in,
    output logic [NOUT-1:0] func_out
);

    logic [NVAR-1:0]         pol0_q;
    logic [NVAR-1:0]         pol1_q;
    logic [NOUT-1:0][MW-1:0] mask_q;
    logic [W-1:0]            w0;
    logic [W-1:0]            w1;

    symarr_cfg #(.NVAR(NVAR), .NOUT(NOUT), .MW(MW), .AW(AW)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_addr (cfg_addr),
        .wr_data (cfg_wdata),
        .pol0_q  (pol0_q),
        .pol1_q  (pol1_q),
        .mask_q  (mask_q)
    );

    symarr_lattice #(.NVAR(NVAR), .W(W)) u_stage0 (
        .vars   (vars_in),
        .pol    (pol0_q),
        .weight (w0)
    );

    symarr_lattice #(.NVAR(NVAR), .W(W)) u_stage1 (
        .vars   (vars_in),
        .pol    (pol1_q),
        .weight (w1)
    );

    symarr_orplane #(.NVAR(NVAR), .NOUT(NOUT), .W(W), .MW(MW)) u_plane (
        .mask (mask_q),
        .w0   (w0),
        .w1   (w1),
        .y    (func_out)
    );

endmodule

// File: rtl/symarr_chk.sv
module symarr_chk #(
    parameter  int NVAR = 4,
    parameter  int NOUT = 4,
    localparam int W    = NVAR + 1,
    localparam int MW   = 2 * W,
    localparam int AW   = $clog2(NOUT + 2)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cfg_we,
    input logic [AW-1:0]           cfg_addr,
    input logic [MW-1:0]           cfg_wdata,
    input logic [NVAR-1:0]         vars_in,
    input logic [NOUT-1:0]         func_out,
    input logic [NVAR-1:0]         pol0,
    input logic [NVAR-1:0]         pol1,
    input logic [NOUT-1:0][MW-1:0] mask,
    input logic [W-1:0]            w0,
    input logic [W-1:0]            w1
);

    a_r2_weight_stage0: assert property (@(posedge clk) disable iff (!rst_n)
        w0[$countones(vars_in ^ pol0)] == 1'b1);

    a_r2_weight_stage1: assert property (@(posedge clk) disable iff (!rst_n)
        w1[$countones(vars_in ^ pol1)] == 1'b1);

    a_r3_onehot_stage0: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(w0) == 1);

    a_r3_onehot_stage1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(w1) == 1);

    a_r5_write_pol0: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == AW'(0)) |=> pol0 == $past(cfg_wdata[NVAR-1:0]));

    a_r5_write_pol1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == AW'(1)) |=> pol1 == $past(cfg_wdata[NVAR-1:0]));

    a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> ($stable(pol0) && $stable(pol1) && $stable(mask)));

    if ((NOUT + 2) < (1 << AW)) begin : g_unused
        a_r6_unused_addr: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && cfg_addr >= AW'(NOUT + 2)) |=>
                ($stable(pol0) && $stable(pol1) && $stable(mask)));
    end

    for (genvar j = 0; j < NOUT; j++) begin : g_per_out
        a_r5_write_mask: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && cfg_addr == AW'(j + 2)) |=> mask[j] == $past(cfg_wdata));

        a_r7_zero_mask: assert property (@(posedge clk) disable iff (!rst_n)
            (mask[j] == '0) |-> !func_out[j]);

        a_r8_full_stage0: assert property (@(posedge clk) disable iff (!rst_n)
            (mask[j][W-1:0] == '1) |-> func_out[j]);

        a_r8_full_stage1: assert property (@(posedge clk) disable iff (!rst_n)
            (mask[j][MW-1:W] == '1) |-> func_out[j]);
    end

endmodule

bind symarr_top symarr_chk #(.NVAR(NVAR), .NOUT(NOUT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .vars_in   (vars_in),
    .func_out  (func_out),
    .pol0      (pol0_q),
    .pol1      (pol1_q),
    .mask      (mask_q),
    .w0        (w0),
    .w1        (w1)
);

// File: tb/tb_symarr_top.sv
`timescale 1ns/1ps
module tb_symarr_top;

    localparam int N  = 4;
    localparam int M  = 4;
    localparam int MW = 2 * (N + 1);
    localparam int AW = $clog2(M + 2);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [MW-1:0] cfg_wdata = '0;
    logic [N-1:0]  vars_in = '0;
    logic [M-1:0]  func_out;

    int n_checks = 0;
    int n_fail = 0;

    logic [N-1:0]  m_pol  [2];
    logic [MW-1:0] m_mask [M];

    always #5 clk = ~clk;

    symarr_top #(.NVAR(N), .NOUT(M)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .vars_in   (vars_in),
        .func_out  (func_out)
    );

    function automatic int ones_after_pol(input logic [N-1:0] v, input logic [N-1:0] p);
        int c = 0;
        for (int b = 0; b < N; b++)
            if (v[b] != p[b]) c++;
        return c;
    endfunction

    function automatic logic [M-1:0] model_out(input logic [N-1:0] v);
        logic [M-1:0] r;
        int c0 = ones_after_pol(v, m_pol[0]);
        int c1 = ones_after_pol(v, m_pol[1]);
        for (int j = 0; j < M; j++)
            r[j] = m_mask[j][c0] | m_mask[j][N + 1 + c1];
        return r;
    endfunction

    task automatic check(input string req, input logic [M-1:0] act, input logic [M-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: func_out=%b expected %b (vars=%b)", req, act, exp, vars_in);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    task automatic write_reg(input int a, input logic [MW-1:0] d);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = AW'(a);
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (a == 0) m_pol[0] = d[N-1:0];
        else if (a == 1) m_pol[1] = d[N-1:0];
        else if (a < M + 2) m_mask[a - 2] = d;
    endtask

    // One input value per clock. Sampled 1 ns after the drive, with no edge in between (R9).
    task automatic sweep(input string req);
        for (int v = 0; v < (1 << N); v++) begin
            @(negedge clk);
            vars_in = N'(v);
            #1;
            check(req, func_out, model_out(vars_in));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog (all requirements): actual=hung expected=complete");
        report();
        $finish;
    end

    initial begin
        m_pol[0] = '0;
        m_pol[1] = '0;
        for (int j = 0; j < M; j++) m_mask[j] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset clears everything, all outputs 0
        sweep("R1 reset state");

        // R2/R4/R7/R8 directed
        write_reg(0, MW'(4'b0000));
        write_reg(1, MW'(4'b1111));
        write_reg(2, MW'(10'b00000_11000));  // stage-0 S3|S4
        write_reg(3, MW'(10'b00001_00000));  // stage-1 S0, i.e. all inputs one
        write_reg(4, MW'(0));                // R7 zero mask
        write_reg(5, MW'(10'b00000_11111));  // R8 full stage 0
        sweep("R2 R4 R7 R8 directed S3|S4, complemented S0");

        write_reg(5, MW'(10'b11111_00000));  // R8 full stage 1
        sweep("R8 full stage-1 mask");

        // R6: unused addresses change nothing
        write_reg(6, '1);
        write_reg(7, '1);
        sweep("R6 unused address write");

        // R10: busy bus with we low
        @(negedge clk);
        cfg_addr  = AW'(2);
        cfg_wdata = '1;
        @(negedge clk);
        cfg_addr  = AW'(0);
        @(negedge clk);
        sweep("R10 idle bus holds config");

        // R3: outputs take stage-1 S0..S3; exactly one is high unless weight is 4
        write_reg(1, MW'(4'b0101));
        for (int j = 0; j < M; j++) write_reg(2 + j, MW'(1) << (N + 1 + j));
        for (int v = 0; v < (1 << N); v++) begin
            @(negedge clk);
            vars_in = N'(v);
            #1;
            check("R3 one-hot weights", func_out, model_out(vars_in));
            n_checks++;
            if ($countones(func_out) != ((ones_after_pol(vars_in, 4'b0101) <= 3) ? 1 : 0)) begin
                n_fail++;
                $display("FAIL R3: ones=%0d expected %0d", $countones(func_out),
                         (ones_after_pol(vars_in, 4'b0101) <= 3) ? 1 : 0);
            end
        end

        // R2/R4/R5 randomised configurations
        for (int t = 0; t < 24; t++) begin
            write_reg(0, MW'($urandom));
            write_reg(1, MW'($urandom));
            for (int j = 0; j < M; j++) write_reg(2 + j, MW'($urandom));
            sweep("R2 R4 R5 random configuration");
        end

        report();
        $finish;
    end

endmodule